// File: doc/BRIEF.md
# UART Receive Byte Queue

This block holds the bytes that a UART channel's serial receiver has finished assembling until the CPU collects them. The receiver side presents one byte per `pushValid` strobe, or signals a line break with `breakEvt`. The CPU side collects bytes with `popStrobe`, which stands for a read of the receive data register. The byte on `popData` is valid in the same cycle as the strobe. A control byte enables the queue and flushes it. When the queue is disabled, a single holding register takes its place.

The block drives several outputs for the register file and the interrupt logic: a status word with the occupancy and a full flag, a data-ready flag, a sticky error-status nibble, and one-cycle error and break pulses. The queue depth is the parameter `DEPTH`, which is 16 by default and may be at most 255.

Top module: `rx_byte_queue`

## Requirements
- R1: `statusWord[7:0]` gives the number of stored bytes and `statusWord[8]` is set exactly when the queue holds `DEPTH` bytes. While that bit is set, bits [7:0] read zero.
- R2: A control write with bit 1 set empties the queue and clears data-ready for the next cycle. A control write with bit 2 set makes `txFlush` high for one cycle after the write. Bits 1 and 2 of `ctlReg` always read zero, and the other bits hold the value written.
- R3: `ctlReg` bit 0 set selects queue mode. In queue mode, bytes come out in the order they arrived, and up to `DEPTH` bytes are held.
- R4: In queue mode, a pop while the queue is empty returns 0x00 on `popData` and raises `errPulse` for the cycle after the pop.
- R5: In queue mode, a byte that arrives while the queue is full and no pop happens in the same cycle is dropped. The stored contents do not change, and `errPulse` is raised for the next cycle.
- R6: `dataReady` is set by every accepted byte. It clears when a pop leaves the queue empty, and it stays set after a pop that leaves bytes behind.
- R7: A break event stores 0x00 as if a byte had arrived, and it takes priority over `pushValid` in the same cycle. It also sets `errStat[3]` and raises `breakPulse` for the next cycle. An `errStatRd` strobe clears `errStat` after the edge, unless a break arrives in the same cycle. The other bits of `errStat` read zero.
- R8: With `ctlReg` bit 0 clear, an incoming byte (a break stores 0x00) overwrites the holding register and sets `dataReady`. A pop returns the holding register and clears `dataReady`. `canAccept` equals the inverse of `dataReady`, and `statusWord` reports the queue's own occupancy.
- R9: A push and a pop in the same cycle leave the count unchanged. This also holds when the queue is full, and in that case the incoming byte is accepted.
- R10: After reset the queue is empty, `ctlReg` is 0 (queue disabled), `dataReady` is 0 and `errStat` is 0.
- R11: In queue mode, `canAccept` is high exactly when fewer than `DEPTH` bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control byte |
| ctlWrData | input | 8 | Control value: bit 0 enable, bit 1 flush receive, bit 2 flush transmit |
| ctlReg | output | 8 | Stored control byte, with the flush bits reading zero |
| pushValid | input | 1 | A received byte is present |
| pushData | input | 8 | Received byte |
| breakEvt | input | 1 | Line break detected |
| canAccept | output | 1 | The receiver may deliver a byte |
| popStrobe | input | 1 | CPU read of the receive data register |
| popData | output | 8 | Byte returned by the read, in the same cycle |
| statusWord | output | 9 | Full flag in bit 8, occupancy in [7:0] |
| dataReady | output | 1 | Receive data available |
| errStatRd | input | 1 | CPU read of the error-status register |
| errStat | output | 4 | Error status, with break in bit 3 |
| errPulse | output | 1 | One-cycle error interrupt source |
| breakPulse | output | 1 | One-cycle break indication |
| txFlush | output | 1 | One-cycle flush request for the transmit queue |

## Verification
The assertions check the following on every cycle:
- the status word's full and count encoding;
- that the flush bits read back as zero;
- the bound on the occupancy;
- how `canAccept` relates to the occupancy in queue mode and to `dataReady` in bypass;
- that the error pulse follows an empty pop or a dropped byte;
- the outcome of a flush and of a break.

Only the bench's scenarios can show byte ordering, the dropped byte's absence from later pops, data-ready across a run of pops, overwrite in bypass, and a simultaneous push and pop at every fill level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic wr;       // store a byte at the write pointer
    logic rd;       // advance the read pointer
    logic flush;    // empty the queue
    logic wrZero;   // stored byte is 0x00 (break)
    logic holdLoad; // load the bypass holding register
  } rxqStrobes_t;
endpackage

// File: rtl/rxq_data.sv
module rxq_data #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rxq_pkg::rxqStrobes_t stb,
  input  logic [7:0]           inByte,
  output logic [CW-1:0]        count,
  output logic [7:0]           headByte,
  output logic [7:0]           holdByte
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [7:0]    storeByte;

  assign storeByte = stb.wrZero ? 8'h00 : inByte;
  assign headByte  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wr) mem[wrPtr] <= storeByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.wr) wrPtr <= nextPtr(wrPtr);
      if (stb.rd) rdPtr <= nextPtr(rdPtr);
      case ({stb.wr, stb.rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            holdByte <= 8'h00;
    else if (stb.holdLoad) holdByte <= storeByte;
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctlWrEn,
  input  logic [7:0]           ctlWrData,
  input  logic                 pushValid,
  input  logic                 breakEvt,
  input  logic                 popStrobe,
  input  logic                 errStatRd,
  input  logic [CW-1:0]        count,
  output rxq_pkg::rxqStrobes_t stb,
  output logic [7:0]           ctlReg,
  output logic                 fifoOn,
  output logic                 dataReady,
  output logic                 canAccept,
  output logic [3:0]           errStat,
  output logic                 errPulse,
  output logic                 breakPulse,
  output logic                 txFlush
);
  logic full, empty, inAny, flushNow, dropErr, emptyErr;

  assign fifoOn   = ctlReg[0];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign inAny    = pushValid | breakEvt;
  assign flushNow = ctlWrEn & ctlWrData[1];

  always_comb begin
    stb          = '0;
    stb.flush    = flushNow;
    stb.wrZero   = breakEvt;
    stb.rd       = fifoOn & popStrobe & ~empty & ~flushNow;
    stb.wr       = fifoOn & inAny & (~full | stb.rd) & ~flushNow;
    stb.holdLoad = ~fifoOn & inAny;
  end

  assign dropErr   = fifoOn & inAny & full & ~stb.rd & ~flushNow;
  assign emptyErr  = fifoOn & popStrobe & empty;
  assign canAccept = fifoOn ? ~full : ~dataReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlReg     <= 8'h00;
      dataReady  <= 1'b0;
      errStat    <= 4'h0;
      errPulse   <= 1'b0;
      breakPulse <= 1'b0;
      txFlush    <= 1'b0;
    end else begin
      if (ctlWrEn) ctlReg <= ctlWrData & 8'hF9;
      if (flushNow)                      dataReady <= 1'b0;
      else if (fifoOn) begin
        if (stb.wr)                      dataReady <= 1'b1;
        else if (stb.rd && count == CW'(1)) dataReady <= 1'b0;
      end else begin
        if (stb.holdLoad)                dataReady <= 1'b1;
        else if (popStrobe)              dataReady <= 1'b0;
      end
      if (breakEvt)       errStat <= 4'h8;
      else if (errStatRd) errStat <= 4'h0;
      errPulse   <= dropErr | emptyErr;
      breakPulse <= breakEvt;
      txFlush    <= ctlWrEn & ctlWrData[2];
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  output logic [7:0] ctlReg,
  input  logic       pushValid,
  input  logic [7:0] pushData,
  input  logic       breakEvt,
  output logic       canAccept,
  input  logic       popStrobe,
  output logic [7:0] popData,
  output logic [8:0] statusWord,
  output logic       dataReady,
  input  logic       errStatRd,
  output logic [3:0] errStat,
  output logic       errPulse,
  output logic       breakPulse,
  output logic       txFlush
);
  localparam int CW = $clog2(DEPTH + 1);

  rxq_pkg::rxqStrobes_t stb;
  logic [CW-1:0] count;
  logic [7:0]    headByte, holdByte;
  logic          fifoOn, isFull;

  rxq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk, .rst_n, .ctlWrEn, .ctlWrData, .pushValid, .breakEvt, .popStrobe,
    .errStatRd, .count, .stb, .ctlReg, .fifoOn, .dataReady, .canAccept,
    .errStat, .errPulse, .breakPulse, .txFlush
  );

  rxq_data #(.DEPTH(DEPTH), .CW(CW)) u_data (
    .clk, .rst_n, .stb, .inByte(pushData), .count, .headByte, .holdByte
  );

  assign isFull     = (count == CW'(DEPTH));
  assign statusWord = {isFull, isFull ? 8'h00 : 8'(count)};
  assign popData    = !fifoOn ? holdByte : ((count == '0) ? 8'h00 : headByte);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic [7:0] ctlReg,
  input logic       pushValid,
  input logic       breakEvt,
  input logic       canAccept,
  input logic       popStrobe,
  input logic [7:0] popData,
  input logic [8:0] statusWord,
  input logic       dataReady,
  input logic [3:0] errStat,
  input logic       errPulse,
  input logic       breakPulse
);
  assert_full_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[8] |-> statusWord[7:0] == 8'h00);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWord[8] |-> statusWord[7:0] < 8'(DEPTH));

  assert_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReg[2:1] == 2'b00);

  assert_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && ctlWrData[1]) |=> (statusWord == 9'h000 && !dataReady));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlReg[0] && popStrobe && statusWord == 9'h000) |-> popData == 8'h00);

  assert_empty_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlReg[0] && popStrobe && statusWord == 9'h000) |=> errPulse);

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlReg[0] && statusWord[8] && (pushValid || breakEvt) && !popStrobe
     && !(ctlWrEn && ctlWrData[1])) |=> (errPulse && statusWord[8]));

  assert_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    breakEvt |=> (errStat[3] && breakPulse));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlReg[0] |-> canAccept == !dataReady);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReg[0] |-> canAccept == !statusWord[8]);
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = 8'h00;
  logic [7:0] ctlReg;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = 8'h00;
  logic       breakEvt = 1'b0;
  logic       canAccept;
  logic       popStrobe = 1'b0;
  logic [7:0] popData;
  logic [8:0] statusWord;
  logic       dataReady;
  logic       errStatRd = 1'b0;
  logic [3:0] errStat;
  logic       errPulse, breakPulse, txFlush;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  rx_byte_queue #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  function automatic int expStatus(input int n);
    return (n == DEPTH) ? 32'h100 : n;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ctlWrite(input logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrData = v;
    tick();
    ctlWrEn = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    pushValid = 1'b1; pushData = b;
    tick();
    pushValid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] got);
    popStrobe = 1'b1;
    #1 got = popData;
    tick();
    popStrobe = 1'b0;
  endtask

  task automatic pushPop(input logic [7:0] b, output logic [7:0] got);
    pushValid = 1'b1; pushData = b; popStrobe = 1'b1;
    #1 got = popData;
    tick();
    pushValid = 1'b0; popStrobe = 1'b0;
  endtask

  task automatic endRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    endRun();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R10 reset state
    checkEq("R10 status", statusWord, 0);
    checkEq("R10 ctl", ctlReg, 0);
    checkEq("R10 dataReady", dataReady, 0);
    checkEq("R10 errStat", errStat, 0);

    ctlWrite(8'h01);
    checkEq("R3 enable", ctlReg, 1);

    // R1 R6 R11 fill sweep
    for (int n = 1; n <= DEPTH; n++) begin
      push(8'(8'hA0 + n));
      checkEq("R1 status fill", statusWord, expStatus(n));
      checkEq("R6 ready after push", dataReady, 1);
      checkEq("R11 canAccept", canAccept, (n < DEPTH) ? 1 : 0);
    end

    // R5 overflow drop
    push(8'hEE);
    checkEq("R5 errPulse", errPulse, 1);
    checkEq("R5 still full", statusWord, 32'h100);

    // R3 R6 drain in order
    for (int i = 1; i <= DEPTH; i++) begin
      pop(got);
      checkEq("R3 order", got, 8'hA0 + i);
      checkEq("R1 status drain", statusWord, DEPTH - i);
      checkEq("R6 ready after pop", dataReady, (i < DEPTH) ? 1 : 0);
    end

    // R4 empty pop
    pop(got);
    checkEq("R4 data zero", got, 0);
    checkEq("R4 errPulse", errPulse, 1);
    checkEq("R4 status", statusWord, 0);
    tick();
    checkEq("R4 pulse one cycle", errPulse, 0);

    // R9 simultaneous push and pop at every fill level
    for (int k = 0; k <= DEPTH; k++) begin
      ctlWrite(8'h03);
      for (int j = 0; j < k; j++) push(8'(8'h10 + j));
      pushPop(8'h77, got);
      if (k == 0) begin
        checkEq("R9 empty pushpop data", got, 0);
        checkEq("R9 empty pushpop count", statusWord, 1);
      end else begin
        checkEq("R9 pushpop data", got, 8'h10);
        checkEq("R9 pushpop count", statusWord, expStatus(k));
        checkEq("R9 no error", errPulse, 0);
      end
    end

    // R2 flush with transmit flush
    ctlWrite(8'h07);
    checkEq("R2 flushed", statusWord, 0);
    checkEq("R2 ready cleared", dataReady, 0);
    checkEq("R2 selfclear", ctlReg, 1);
    checkEq("R2 txFlush", txFlush, 1);
    tick();
    checkEq("R2 txFlush one cycle", txFlush, 0);

    // R7 break
    pushValid = 1'b1; pushData = 8'h99; breakEvt = 1'b1;
    tick();
    pushValid = 1'b0; breakEvt = 1'b0;
    checkEq("R7 breakPulse", breakPulse, 1);
    checkEq("R7 errStat", errStat, 8);
    checkEq("R7 count", statusWord, 1);
    pop(got);
    checkEq("R7 null byte", got, 0);
    errStatRd = 1'b1;
    tick();
    errStatRd = 1'b0;
    checkEq("R7 errStat cleared", errStat, 0);

    // R8 bypass
    ctlWrite(8'h00);
    checkEq("R8 canAccept idle", canAccept, 1);
    push(8'h5A);
    checkEq("R8 ready", dataReady, 1);
    checkEq("R8 canAccept busy", canAccept, 0);
    push(8'h66);
    checkEq("R8 status unused", statusWord, 0);
    pop(got);
    checkEq("R8 overwrite data", got, 8'h66);
    checkEq("R8 ready cleared", dataReady, 0);
    checkEq("R8 canAccept again", canAccept, 1);

    endRun();
  end
endmodule